// File: doc/BRIEF.md
# Triggered Triangle Waveform Generator

This block produces a digital triangle wave for one channel of a 12-bit converter datapath. An internal counter climbs from zero to a programmable peak and then falls back to zero, over and over. Each accepted trigger pulse adds the counter's present value to a 12-bit base word. The result is clamped to full scale and written into the output data register after a fixed pipeline delay. The counter moves one step only when that write happens.

A 4-bit amplitude field sets the peak of the counter. A 2-bit wave-mode field selects triangle operation when its upper bit is set. In the other modes a trigger copies the base word to the output unchanged. Several instances can take the same trigger pulse and enable with different amplitude settings. They then update on the same cycle but reach different heights. Selecting the trigger source, decoding bus registers and the analog converter all sit outside this block.

Top module: `tri_wave_gen`

## Requirements
- R1: Triangle mode is active when `wave_mode_i[1]` is 1 (modes 2'b10 and 2'b11). In modes 2'b00 and 2'b01 a trigger loads `base_i` into `dout_o` as it is, and the counter keeps its value and direction.
- R2: With amplitude field A, the counter's peak is 2^(A+1)-1. A is clamped to 11, so values 11 to 15 all give 4095. Starting from 0 and counting up, the counter runs 0,1,...,peak and then peak-1,...,0,1,... (for A=0 the sequence is 0,1,0,1). The amplitude used is the one present when the counter steps.
- R3: In triangle mode `dout_o` becomes `base_i` plus the counter value, saturated at 0xFFF instead of wrapping.
- R4: When a trigger is accepted on clock edge E0, `dout_o` changes at edge E0+3 and holds its value at every other edge. `base_i` is sampled at E0+3, and the wave mode is sampled at E0.
- R5: The sum uses the counter value from before the step. The counter advances at the same edge that writes `dout_o`, so the next trigger sees the new value.
- R6: A trigger is ignored when `trig_en_i` is 0.
- R7: A trigger that arrives at any of the three edges after an accepted trigger (E0+1 to E0+3) is ignored. The earliest edge at which a new trigger is accepted is E0+4.
- R8: Synchronous reset (`rst` high) clears `dout_o` to 0, clears the counter to 0 and sets the direction to up.
- R9: Two instances that share `trig_i` and `trig_en_i` but have different amplitudes update `dout_o` on the same edge and follow their own triangle sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger pulse, sampled at each rising edge |
| trig_en_i | input | 1 | Trigger enable |
| wave_mode_i | input | 2 | Wave mode; upper bit set selects triangle |
| amp_i | input | 4 | Amplitude field; peak is 2^(amp+1)-1 |
| base_i | input | 12 | Base data word added to the counter |
| dout_o | output | 12 | Output data register |

## Verification
The main sequence of triggers walks through three amplitudes (0, 1 and 2). This separates a peak computed as 2^(A+1)-1 from off-by-one variants, and it checks that the counter turns around at the peak and at zero. It also checks that an amplitude change mid-run takes effect from the current count.

Base words near full scale separate saturation from wrap-around. One case sits exactly at 0xFFF, so an off-by-one clamp is also caught. Non-triangle modes placed between triangle triggers show that the counter holds its value and direction.

The output is checked one cycle before the expected write and again on the write, which pins the three-cycle delay. Triggers sent while disabled or during the latency window are followed by a normal trigger, which shows at the port that the counter did not move. A second instance with a smaller amplitude runs alongside on the shared trigger to show both channels updating together at different heights.

// File: rtl/tri_pkg.sv
package tri_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} tri_dir_e;
  localparam int TRI_SEL_BIT = 1;
endpackage

// File: rtl/tri_trig_ctl.sv
module tri_trig_ctl #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  input  logic en_i,
  input  logic tri_mode_i,
  output logic commit_o,
  output logic commit_tri_o
);
  logic [LAT-1:0] vld_q;
  logic [LAT-1:0] tri_q;
  logic           busy;
  logic           accept;

  assign busy   = |vld_q;
  assign accept = trig_i && en_i && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      tri_q <= '0;
    end else begin
      vld_q[0] <= accept;
      tri_q[0] <= accept && tri_mode_i;
      for (int i = 1; i < LAT; i++) begin
        vld_q[i] <= vld_q[i-1];
        tri_q[i] <= tri_q[i-1];
      end
    end
  end

  assign commit_o     = vld_q[LAT-1];
  assign commit_tri_o = tri_q[LAT-1];

  // R7: only one update may be in flight
  assert_single_flight_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vld_q));
  // R6: a disabled trigger starts nothing
  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !vld_q[0]);
endmodule

// File: rtl/tri_step.sv
module tri_step
  import tri_pkg::*;
#(
  parameter int DW = 12,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_i,
  input  logic [AW-1:0] amp_i,
  output logic [DW-1:0] cnt_o
);
  localparam int MAX_SH = DW - 1;

  logic [DW-1:0] cnt_q;
  tri_dir_e      dir_q;
  logic [DW:0]   peak_w;
  logic [DW-1:0] peak;
  int unsigned   sh;

  always_comb begin
    sh = (int'(amp_i) > MAX_SH) ? MAX_SH : int'(amp_i);
    peak_w = ({{DW{1'b0}}, 1'b1} << (sh + 1)) - {{DW{1'b0}}, 1'b1};
    peak = peak_w[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (step_i) begin
      if (dir_q == DIR_UP) begin
        if (cnt_q >= peak) begin
          cnt_q <= cnt_q - 1'b1;
          dir_q <= DIR_DOWN;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_q <= cnt_q + 1'b1;
          dir_q <= DIR_UP;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;

  // R2: each step moves the counter by exactly one
  assert_unit_step_R2: assert property (@(posedge clk) disable iff (rst)
    step_i |=> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1));
  // R5: counter holds between updates
  assert_hold_cnt_R5: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/tri_sum_sat.sv
module tri_sum_sat #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit_i,
  input  logic          add_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] cnt_i,
  output logic [DW-1:0] dout_o
);
  logic [DW:0]   sum_w;
  logic [DW-1:0] sat_w;
  logic [DW-1:0] next_w;

  always_comb begin
    sum_w  = {1'b0, base_i} + {1'b0, cnt_i};
    sat_w  = sum_w[DW] ? {DW{1'b1}} : sum_w[DW-1:0];
    next_w = add_i ? sat_w : base_i;
  end

  always_ff @(posedge clk) begin
    if (rst)           dout_o <= '0;
    else if (commit_i) dout_o <= next_w;
  end

  // R3: a triangle update never lands below the base word
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (commit_i && add_i) |=> dout_o >= $past(base_i));
  // R1: a plain update copies the base word
  assert_plain_copy_R1: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !add_i) |=> dout_o == $past(base_i));
endmodule

// File: rtl/tri_wave_gen.sv
module tri_wave_gen
  import tri_pkg::*;
#(
  parameter int DW  = 12,
  parameter int AW  = 4,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig_i,
  input  logic          trig_en_i,
  input  logic [1:0]    wave_mode_i,
  input  logic [AW-1:0] amp_i,
  input  logic [DW-1:0] base_i,
  output logic [DW-1:0] dout_o
);
  logic          commit;
  logic          commit_tri;
  logic [DW-1:0] cnt;

  tri_trig_ctl #(.LAT(LAT)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .trig_i       (trig_i),
    .en_i         (trig_en_i),
    .tri_mode_i   (wave_mode_i[TRI_SEL_BIT]),
    .commit_o     (commit),
    .commit_tri_o (commit_tri)
  );

  tri_step #(.DW(DW), .AW(AW)) u_step (
    .clk    (clk),
    .rst    (rst),
    .step_i (commit_tri),
    .amp_i  (amp_i),
    .cnt_o  (cnt)
  );

  tri_sum_sat #(.DW(DW)) u_sum (
    .clk      (clk),
    .rst      (rst),
    .commit_i (commit),
    .add_i    (commit_tri),
    .base_i   (base_i),
    .cnt_i    (cnt),
    .dout_o   (dout_o)
  );

  // R4: output moves only on a commit edge
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(dout_o));
  // R8: reset clears output and counter
  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (dout_o == '0) && (cnt == '0));
endmodule

// File: tb/tri_wave_gen_test.sv
module tri_wave_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0;
  logic        en = 1'b1;
  logic [1:0]  mode = 2'b10;
  logic [3:0]  amp = 4'd0;
  logic [11:0] base = 12'h000;
  logic [11:0] dout;
  logic [11:0] dout_b;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tri_wave_gen uut (
    .clk(clk), .rst(rst), .trig_i(trig), .trig_en_i(en),
    .wave_mode_i(mode), .amp_i(amp), .base_i(base), .dout_o(dout));

  // R9: second channel, same trigger, amplitude 0, base 0
  tri_wave_gen uut_b (
    .clk(clk), .rst(rst), .trig_i(trig), .trig_en_i(en),
    .wave_mode_i(2'b10), .amp_i(4'd0), .base_i(12'h000), .dout_o(dout_b));

  // {mode, amp, base, expected}
  localparam logic [29:0] VEC [14] = '{
    {2'b10, 4'd0, 12'h100, 12'h100},
    {2'b10, 4'd0, 12'h100, 12'h101},
    {2'b10, 4'd0, 12'h100, 12'h100},
    {2'b10, 4'd1, 12'h200, 12'h201},
    {2'b10, 4'd1, 12'h200, 12'h202},
    {2'b10, 4'd1, 12'h200, 12'h203},
    {2'b10, 4'd1, 12'h200, 12'h202},
    {2'b00, 4'd1, 12'h345, 12'h345},
    {2'b01, 4'd1, 12'h050, 12'h050},
    {2'b10, 4'd1, 12'hFFF, 12'hFFF},
    {2'b10, 4'd1, 12'hFFF, 12'hFFF},
    {2'b10, 4'd2, 12'hFFE, 12'hFFF},
    {2'b10, 4'd2, 12'hFFE, 12'hFFF},
    {2'b11, 4'd2, 12'h000, 12'h003}
  };

  task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Trigger high across edge E0; checks one edge early and on E0+3
  task automatic fire(input logic [1:0] m, input logic [3:0] a,
                      input logic [11:0] b, input logic [11:0] exp, input string tag);
    logic [11:0] prev;
    prev = dout;
    mode = m; amp = a; base = b; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(dout, prev, {"R4 early ", tag});
    @(negedge clk);
    chk(dout, exp, tag);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dout, 12'h000, "R8 reset output");

    // Main table: R1 R2 R3 R5
    for (int i = 0; i < 14; i++) begin
      fire(VEC[i][29:28], VEC[i][27:24], VEC[i][23:12], VEC[i][11:0], "R2 R3 R5 vector");
    end

    // R6: disabled trigger, counter must stay at 4
    en = 1'b0; mode = 2'b10; amp = 4'd2; base = 12'h000; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    repeat (4) @(negedge clk);
    chk(dout, 12'h003, "R6 disabled no update");
    en = 1'b1;
    fire(2'b10, 4'd2, 12'h000, 12'h004, "R6 counter unmoved");

    // R7: extra triggers at E0+1 and E0+3 ignored
    mode = 2'b10; amp = 4'd2; base = 12'h000; trig = 1'b1;
    @(negedge clk);            // E0 passed
    @(negedge clk); trig = 1'b0; // E1 passed with trig high
    @(negedge clk); trig = 1'b1; // E2 passed
    @(negedge clk); trig = 1'b0; // E3 passed with trig high
    chk(dout, 12'h005, "R7 first update");
    repeat (4) @(negedge clk);
    chk(dout, 12'h005, "R7 no second update");
    fire(2'b10, 4'd2, 12'h000, 12'h006, "R7 single step");

    // R8: reset again, counter back to 0 going up
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(dout, 12'h000, "R8 reset clears output");
    chk(dout_b, 12'h000, "R8 reset second channel");

    // R9: shared trigger, amplitudes 2 and 0
    fire(2'b10, 4'd2, 12'h000, 12'h000, "R8 R9 ch a step0");
    chk(dout_b, 12'h000, "R9 ch b step0");
    fire(2'b10, 4'd2, 12'h000, 12'h001, "R9 ch a step1");
    chk(dout_b, 12'h001, "R9 ch b step1");
    fire(2'b10, 4'd2, 12'h000, 12'h002, "R9 ch a step2");
    chk(dout_b, 12'h000, "R9 ch b step2");
    fire(2'b10, 4'd2, 12'h000, 12'h003, "R9 ch a step3");
    chk(dout_b, 12'h001, "R9 ch b step3");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule